// File: doc/BRIEF.md
# Serial Controller Register and Interrupt Unit

This block is the processor-facing side of a classic 8-bit asynchronous serial controller. A host reaches it over a byte-wide bus with a 3-bit register address, a chip select and separate read and write strobes. It holds the configuration registers and a 16-bit baud divisor. It buffers received and outgoing bytes in two 16-entry queues. It ranks five interrupt causes and presents the highest one through an identification register and a single interrupt line.

Bit-level shifting is left to a neighbouring block. That block hands in each received byte with a one-cycle valid strobe and three error flags (parity, framing, break). It takes outgoing bytes through a valid/ready pair and reports with a busy flag while its shifter is still sending. The divisor, the line-control byte and the modem-control bits are brought out for it. Four modem inputs are sampled for the status register. A read returns data combinationally in the cycle the read strobe is high; any read side effect takes place at that cycle's rising clock edge.

Top module: `uart_regif`

## Requirements
- R1: With line-control bit 7 set, address 0 reads/writes the divisor low byte and address 1 the high byte, and `divisor` = {high, low}. With bit 7 clear, address 1 is the interrupt-enable register: only bits 3:0 are kept and bits 7:4 read 0.
- R2: Address 3 (line control, 8 bits) and address 7 (scratch, 8 bits) read back what was written. Address 4 (modem control) keeps bits 4:0, and bits 7:5 read 0.
- R3: Received bytes leave address 0 in arrival order. The queue holds 16 bytes in queue mode and 1 byte otherwise. A byte that arrives when the queue is full is dropped and sets status bit 1 (overrun). Status bit 0 is 1 while the queue holds data.
- R4: Bytes written to address 0 appear on `tx_byte` in write order while `tx_valid` is high, one per cycle with `tx_ready` high. Status bit 5 is 1 when the outgoing queue is empty. Status bit 6 is 1 when that queue is empty and `tx_busy` is low.
- R5: A write to address 2 with bit 1 set empties the receive queue, and one with bit 2 set empties the outgoing queue. These bits act once and are not held, so a later write without them clears nothing. A write that changes bit 0 (queue mode) empties both queues.
- R6: Identification (address 2 read) bits 7:6 read 11 in queue mode and 00 otherwise, and bits 5:4 read 0. With nothing pending, bits 3:0 read 0x1.
- R7: With enable bit 0 set, code 0x4 is reported once the receive queue holds at least the trigger level. The level is 1, 4, 8 or 14 for write-2 bits 7:6 = 00, 01, 10, 11. Outside queue mode the level is 1.
- R8: In queue mode, with enable bit 0 set, code 0xC is reported when the receive queue has stayed non-empty with no push or pop for 64·D·F clock cycles. Here D is the divisor and F = 1 + 5 + lc[1:0] + lc[3] + (lc[2] ? 2 : 1). A read of address 0 withdraws it.
- R9: A byte arriving with its parity, framing or break flag sets status bit 2, 3 or 4 respectively. With enable bit 2 set, code 0x6 is reported while any of status bits 1-4 is set. A read of address 5 clears bits 1-4. In queue mode, status bit 7 is 1 while the receive queue holds a byte that arrived with an error flag.
- R10: With enable bit 1 set, code 0x2 is reported after the outgoing queue becomes empty, or when bit 1 is enabled while that queue is empty. The code is withdrawn by a read of address 2 that returns it, or by a write to address 0.
- R11: Address 6 reads {current `modem_in`[3:0], deltas}. `modem_in` bit 0 is clear-to-send, bit 1 data-set-ready, bit 2 ring and bit 3 carrier. Delta bits 0, 1 and 3 record any change of their input. Delta bit 2 records ring going from 1 to 0. With enable bit 3 set, code 0x0 is reported while a delta is set, and a read of address 6 clears the deltas.
- R12: When several causes are pending, the reported code follows the order line status (0x6), then receive data or timeout (0x4/0xC), then outgoing empty (0x2), then modem (0x0).
- R13: `irq` is high exactly when identification bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on this byte |
| rx_ferr | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Break seen on this byte |
| tx_valid | output | 1 | An outgoing byte is available |
| tx_byte | output | 8 | Outgoing byte at the queue head |
| tx_ready | input | 1 | Shifter takes the head byte this cycle |
| tx_busy | input | 1 | Shifter is still sending |
| modem_in | input | 4 | {carrier, ring, data-set-ready, clear-to-send} |
| divisor | output | 16 | Baud divisor (baud = clock / (16·divisor)) |
| line_ctrl | output | 8 | Line-control register |
| modem_ctrl | output | 5 | Modem-control register |

## Verification
Receive and transmit are tried with random burst lengths from 1 to 16 and random trigger levels. These runs tell apart ordering faults, pointer wrap faults and trigger-compare off-by-one errors, because the burst length lands on every side of every level. Directed sequences push one byte more than the queue holds in both modes, which separates the full check from the depth setting. They also let a single byte age past the timeout window and then read it before that window, which shows the timer's scale. Pending causes are stacked pairwise (line status over receive, outgoing empty over modem) to expose a wrong priority. The purge bits, the queue-mode toggle and the modem deltas are each checked with a repeat access, which separates clear-on-read and one-shot behaviour from held state.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  typedef enum logic [3:0] {
    IIR_MS   = 4'h0,
    IIR_NONE = 4'h1,
    IIR_THRE = 4'h2,
    IIR_RDA  = 4'h4,
    IIR_LS   = 4'h6,
    IIR_CTO  = 4'hC
  } iir_code_e;

  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_IER  = 3'd1,
    A_IIR  = 3'd2,
    A_LCR  = 3'd3,
    A_MCR  = 3'd4,
    A_LSR  = 3'd5,
    A_MSR  = 3'd6,
    A_SCR  = 3'd7
  } reg_addr_e;

  // receive trigger level selected by control bits 7:6
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // bits per character frame: start + data + parity + stop
  function automatic logic [3:0] frame_bits(input logic [7:0] lc);
    return 4'd6 + {2'b00, lc[1:0]} + {3'b000, lc[3]} + (lc[2] ? 4'd2 : 4'd1);
  endfunction

  // four characters, sixteen clocks per bit per divisor step
  function automatic logic [31:0] char_timeout(input logic [15:0] div,
                                               input logic [7:0]  lc);
    return 32'd64 * 32'(div) * 32'(frame_bits(lc));
  endfunction

  function automatic iir_code_e pick_iir(input logic ls, input logic rda,
                                         input logic cto, input logic thre,
                                         input logic ms);
    if (ls)        return IIR_LS;
    else if (rda)  return IIR_RDA;
    else if (cto)  return IIR_CTO;
    else if (thre) return IIR_THRE;
    else if (ms)   return IIR_MS;
    else           return IIR_NONE;
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int FLAGS = 0,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int OUT_W = W - FLAGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [OUT_W-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             flag_any
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop && (count != '0);
  assign dout   = mem[rd_ptr][OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(do_pop);
    end
  end

  generate
    if (FLAGS > 0) begin : g_flags
      always_comb begin
        flag_any = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) < count)
            flag_any = flag_any | (|mem[(int'(rd_ptr) + i) % DEPTH][W-1 -: FLAGS]);
        end
      end
    end else begin : g_noflags
      assign flag_any = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/uart_char_timer.sv
module uart_char_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm || kick) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == limit - TW'(1)) expired <= 1'b1;
      cnt <= cnt + TW'(1);
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regif_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       ls_pend,
  input  logic       rda_pend,
  input  logic       cto_pend,
  input  logic       thre_pend,
  input  logic       ms_pend,
  output logic [3:0] code,
  output logic       irq
);
  iir_code_e sel;

  assign sel  = pick_iir(ier[2] & ls_pend, ier[0] & rda_pend, ier[0] & cto_pend,
                         ier[1] & thre_pend, ier[3] & ms_pend);
  assign code = sel;
  assign irq  = (sel != IIR_NONE);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          TMR_W     = 32,
  parameter logic [15:0] DIV_RESET = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  input  logic        tx_busy,
  input  logic [3:0]  modem_in,
  output logic [15:0] divisor,
  output logic [7:0]  line_ctrl,
  output logic [4:0]  modem_ctrl
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0] lcr, dll, dlm, scr;
  logic [4:0] mcr;
  logic [3:0] ier;
  logic       fifo_en;
  logic [1:0] trig_sel;
  logic       lsr_oe, lsr_pe, lsr_fe, lsr_bi;
  logic [3:0] modem_q, msr_delta;
  logic       thre_pend;

  // access decode
  logic dlab, acc_wr, acc_rd;
  logic wr_thr, wr_dll, wr_dlm, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
  logic rd_rbr, rd_iir, rd_lsr, rd_msr;

  assign dlab   = lcr[7];
  assign acc_wr = cs && wr;
  assign acc_rd = cs && rd;
  assign wr_thr = acc_wr && addr == A_DATA && !dlab;
  assign wr_dll = acc_wr && addr == A_DATA && dlab;
  assign wr_ier = acc_wr && addr == A_IER && !dlab;
  assign wr_dlm = acc_wr && addr == A_IER && dlab;
  assign wr_fcr = acc_wr && addr == A_IIR;
  assign wr_lcr = acc_wr && addr == A_LCR;
  assign wr_mcr = acc_wr && addr == A_MCR;
  assign wr_scr = acc_wr && addr == A_SCR;
  assign rd_rbr = acc_rd && addr == A_DATA && !dlab;
  assign rd_iir = acc_rd && addr == A_IIR;
  assign rd_lsr = acc_rd && addr == A_LSR;
  assign rd_msr = acc_rd && addr == A_MSR;

  // queues
  logic [CNT_W-1:0] cap, rx_count, tx_count;
  logic [7:0]       rx_head, tx_head;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             rx_flag_any, tx_flag_any;
  logic             mode_flip, clr_rx, clr_tx, rx_push, tx_push, tx_pop;

  assign cap       = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign rx_full   = rx_count >= cap;
  assign tx_full   = tx_count >= cap;
  assign rx_empty  = rx_count == '0;
  assign tx_empty  = tx_count == '0;
  assign mode_flip = wr_fcr && (wdata[0] != fifo_en);
  assign clr_rx    = wr_fcr && (wdata[1] || mode_flip);
  assign clr_tx    = wr_fcr && (wdata[2] || mode_flip);
  assign rx_push   = rx_valid && !rx_full;
  assign tx_push   = wr_thr && !tx_full;
  assign tx_pop    = tx_ready && !tx_empty;

  uart_byte_fifo #(.W(11), .DEPTH(DEPTH), .FLAGS(3)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(rx_push),
    .din({rx_brk, rx_ferr, rx_perr, rx_byte}), .pop(rd_rbr),
    .dout(rx_head), .count(rx_count), .flag_any(rx_flag_any));

  uart_byte_fifo #(.W(8), .DEPTH(DEPTH), .FLAGS(0)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_tx), .push(tx_push),
    .din(wdata), .pop(tx_pop),
    .dout(tx_head), .count(tx_count), .flag_any(tx_flag_any));

  // character timeout
  logic [TMR_W-1:0] cto_limit;
  logic             cto_hit;

  assign cto_limit = TMR_W'(char_timeout({dlm, dll}, lcr));

  uart_char_timer #(.TW(TMR_W)) u_cto (
    .clk(clk), .rst_n(rst_n), .arm(fifo_en && !rx_empty),
    .kick(rx_valid || rd_rbr || clr_rx), .limit(cto_limit), .expired(cto_hit));

  // interrupt causes
  logic       ls_pend, rda_pend, cto_pend, ms_pend;
  logic [3:0] iir_code;
  logic       tx_went_empty, thre_enable_rise;

  assign ls_pend  = lsr_oe | lsr_pe | lsr_fe | lsr_bi;
  assign rda_pend = !rx_empty && (rx_count >= (fifo_en ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1)));
  assign cto_pend = fifo_en && cto_hit;
  assign ms_pend  = |msr_delta;

  assign tx_went_empty    = (tx_pop && tx_count == CNT_W'(1) && !wr_thr) || (clr_tx && !tx_empty);
  assign thre_enable_rise = wr_ier && wdata[1] && !ier[1] && tx_empty;

  uart_irq_prio u_prio (
    .ier(ier), .ls_pend(ls_pend), .rda_pend(rda_pend), .cto_pend(cto_pend),
    .thre_pend(thre_pend), .ms_pend(ms_pend), .code(iir_code), .irq(irq));

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr      <= 8'h00;
      mcr      <= 5'h00;
      ier      <= 4'h0;
      scr      <= 8'h00;
      {dlm, dll} <= DIV_RESET;
      fifo_en  <= 1'b0;
      trig_sel <= 2'd0;
    end else begin
      if (wr_lcr) lcr <= wdata;
      if (wr_mcr) mcr <= wdata[4:0];
      if (wr_ier) ier <= wdata[3:0];
      if (wr_scr) scr <= wdata;
      if (wr_dll) dll <= wdata;
      if (wr_dlm) dlm <= wdata;
      if (wr_fcr) begin
        fifo_en  <= wdata[0];
        trig_sel <= wdata[7:6];
      end
    end
  end

  // line status: clear on read, new events win
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {lsr_oe, lsr_pe, lsr_fe, lsr_bi} <= 4'b0;
    end else begin
      if (rd_lsr) {lsr_oe, lsr_pe, lsr_fe, lsr_bi} <= 4'b0;
      if (rx_valid && !clr_rx) begin
        if (rx_full) lsr_oe <= 1'b1;
        else begin
          if (rx_perr) lsr_pe <= 1'b1;
          if (rx_ferr) lsr_fe <= 1'b1;
          if (rx_brk)  lsr_bi <= 1'b1;
        end
      end
    end
  end

  // outgoing-empty pending
  always_ff @(posedge clk) begin
    if (!rst_n) thre_pend <= 1'b0;
    else if (tx_went_empty || thre_enable_rise) thre_pend <= 1'b1;
    else if (wr_thr || (rd_iir && iir_code == IIR_THRE)) thre_pend <= 1'b0;
  end

  // modem status deltas
  logic [3:0] delta_now;
  assign delta_now = {modem_in[3] ^ modem_q[3], modem_q[2] & ~modem_in[2],
                      modem_in[1] ^ modem_q[1], modem_in[0] ^ modem_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modem_q   <= 4'h0;
      msr_delta <= 4'h0;
    end else begin
      modem_q   <= modem_in;
      msr_delta <= (rd_msr ? 4'h0 : msr_delta) | delta_now;
    end
  end

  // read mux
  logic [7:0] lsr;
  assign lsr = {fifo_en & (rx_flag_any | tx_flag_any), tx_empty & ~tx_busy, tx_empty,
                lsr_bi, lsr_fe, lsr_pe, lsr_oe, ~rx_empty};

  always_comb begin
    case (addr)
      A_DATA:  rdata = dlab ? dll : rx_head;
      A_IER:   rdata = dlab ? dlm : {4'h0, ier};
      A_IIR:   rdata = {fifo_en, fifo_en, 2'b00, iir_code};
      A_LCR:   rdata = lcr;
      A_MCR:   rdata = {3'b000, mcr};
      A_LSR:   rdata = lsr;
      A_MSR:   rdata = {modem_q, msr_delta};
      default: rdata = scr;
    endcase
  end

  assign tx_valid   = !tx_empty;
  assign tx_byte    = tx_head;
  assign divisor    = {dlm, dll};
  assign line_ctrl  = lcr;
  assign modem_ctrl = mcr;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             rd,
  input logic             wr,
  input logic [2:0]       addr,
  input logic             purge_rx,
  input logic             rdata_b0,
  input logic             rx_valid,
  input logic             irq,
  input logic             dlab,
  input logic             fifo_en,
  input logic [CNT_W-1:0] rx_count,
  input logic             ls_pend,
  input logic             thre_pend
);
  a_r13_irq_vs_iir: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 3'd2) |-> (rdata_b0 == !irq));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

  a_r3_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> rx_count <= CNT_W'(1));

  a_r5_rx_purge: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd2 && purge_rx) |=> rx_count == '0);

  a_r9_lsr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 3'd5 && !rx_valid) |=> !ls_pend);

  a_r10_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 3'd0 && !dlab) |=> !thre_pend);
endmodule

bind uart_regif uart_regif_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .purge_rx(wdata[1]), .rdata_b0(rdata[0]), .rx_valid(rx_valid), .irq(irq),
  .dlab(dlab), .fifo_en(fifo_en), .rx_count(rx_count), .ls_pend(ls_pend),
  .thre_pend(thre_pend));

// File: tb/sim_uart_regif.sv
module sim_uart_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;
  logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0] rx_byte = '0;
  logic       tx_valid, tx_ready = 0, tx_busy = 0;
  logic [7:0] tx_byte;
  logic [3:0] modem_in = '0;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl;
  logic [4:0]  modem_ctrl;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_regif u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .modem_in(modem_in), .divisor(divisor),
    .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl));

  // bench-side restatement of the requirements
  function automatic int b_trig(input int sel);
    int lv [4] = '{1, 4, 8, 14};
    return lv[sel];
  endfunction

  function automatic logic [7:0] b_iir(input bit fifo, input bit ls, input bit rx,
                                       input bit thre, input bit ms);
    logic [3:0] c = 4'h1;
    if (ms)   c = 4'h0;
    if (thre) c = 4'h2;
    if (rx)   c = 4'h4;
    if (ls)   c = 4'h6;
    return {fifo, fifo, 2'b00, c};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #2 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd_reg(a, d);
    chk(tag, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic push_rx(input logic [7:0] b, input logic [2:0] err);
    @(negedge clk); rx_valid = 1; rx_byte = b; {rx_brk, rx_ferr, rx_perr} = err;
    @(negedge clk); rx_valid = 0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
  endtask

  task automatic pull_tx(output logic [7:0] b, output logic v);
    @(negedge clk); v = tx_valid; b = tx_byte; tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] d, b;
    logic       v;
    logic [7:0] model [16];
    int unsigned seed_out;
    seed_out = $urandom(32'd24681);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd_chk("R6 reset iir", 3'd2, 8'h01);
    chk("R13 reset irq", {31'h0, irq}, 32'h0);
    rd_chk("R4 reset lsr", 3'd5, 8'h60);

    // R2 plain registers
    wr_reg(3'd3, 8'h1B); rd_chk("R2 lcr", 3'd3, 8'h1B);
    wr_reg(3'd4, 8'hFF); rd_chk("R2 mcr", 3'd4, 8'h1F);
    wr_reg(3'd7, 8'hA5); rd_chk("R2 scratch", 3'd7, 8'hA5);

    // R1 divisor aliasing
    wr_reg(3'd3, 8'h83); wr_reg(3'd0, 8'h34); wr_reg(3'd1, 8'h12);
    rd_chk("R1 dll", 3'd0, 8'h34); rd_chk("R1 dlm", 3'd1, 8'h12);
    chk("R1 divisor port", {16'h0, divisor}, 32'h1234);
    wr_reg(3'd3, 8'h03); wr_reg(3'd1, 8'hFF);
    rd_chk("R1 ier", 3'd1, 8'h0F);
    wr_reg(3'd3, 8'h80); wr_reg(3'd0, 8'h01); wr_reg(3'd1, 8'h00);
    wr_reg(3'd3, 8'h00); wr_reg(3'd1, 8'h00);
    chk("R1 divisor one", {16'h0, divisor}, 32'h0001);

    // R3 single-slot mode overrun
    push_rx(8'h3C, 3'b000); push_rx(8'hC3, 3'b000);
    rd_chk("R3 overrun lsr", 3'd5, 8'h63);
    rd_chk("R3 kept byte", 3'd0, 8'h3C);
    rd_chk("R3 lsr after", 3'd5, 8'h60);

    // R7 trigger 4 in queue mode
    wr_reg(3'd2, 8'h47);
    rd_chk("R6 queue mode iir", 3'd2, 8'hC1);
    wr_reg(3'd1, 8'h01);
    for (int i = 0; i < 3; i++) push_rx(8'h10 + 8'(i), 3'b000);
    rd_chk("R7 below trigger", 3'd2, 8'hC1);
    push_rx(8'h13, 3'b000);
    rd_chk("R7 at trigger", 3'd2, 8'hC4);
    chk("R13 irq high", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 4; i++) rd_chk("R3 order", 3'd0, 8'h10 + 8'(i));

    // R3 queue-mode overrun: 17 pushes
    for (int i = 0; i < 17; i++) push_rx(8'(i), 3'b000);
    rd_chk("R3 full overrun lsr", 3'd5, 8'h63);
    for (int i = 0; i < 16; i++) rd_chk("R3 full order", 3'd0, 8'(i));
    rd_chk("R3 drained", 3'd5, 8'h60);

    // R8 timeout: divisor 1, 5 bits, 1 stop, no parity -> 448 cycles
    push_rx(8'h77, 3'b000);
    repeat (400) @(negedge clk);
    rd_chk("R8 before window", 3'd2, 8'hC1);
    repeat (100) @(negedge clk);
    rd_chk("R8 timeout code", 3'd2, 8'hCC);
    rd_chk("R8 byte", 3'd0, 8'h77);
    rd_chk("R8 withdrawn", 3'd2, 8'hC1);

    // R9 / R12 line status over receive data
    wr_reg(3'd1, 8'h05);
    push_rx(8'hE1, 3'b001);
    rd_chk("R9 ls code", 3'd2, 8'hC6);
    for (int i = 0; i < 3; i++) push_rx(8'hE2 + 8'(i), 3'b000);
    rd_chk("R12 ls over rda", 3'd2, 8'hC6);
    rd_chk("R9 lsr bits", 3'd5, 8'hE5);
    rd_chk("R12 rda next", 3'd2, 8'hC4);
    for (int i = 0; i < 4; i++) rd_chk("R9 bytes", 3'd0, 8'hE1 + 8'(i));
    rd_chk("R9 lsr clean", 3'd5, 8'h60);

    // R5 purge bits
    wr_reg(3'd1, 8'h00);
    for (int i = 0; i < 3; i++) push_rx(8'h50, 3'b000);
    wr_reg(3'd2, 8'h43);
    rd_chk("R5 rx purged", 3'd5, 8'h60);
    wr_reg(3'd0, 8'hAA); wr_reg(3'd0, 8'hBB);
    rd_chk("R4 tx full lsr", 3'd5, 8'h00);
    wr_reg(3'd2, 8'h41);
    rd_chk("R5 no hold", 3'd5, 8'h00);
    wr_reg(3'd2, 8'h45);
    rd_chk("R5 tx purged", 3'd5, 8'h60);

    // R10 outgoing-empty interrupt
    wr_reg(3'd1, 8'h02);
    rd_chk("R10 code", 3'd2, 8'hC2);
    rd_chk("R10 read clears", 3'd2, 8'hC1);
    wr_reg(3'd0, 8'h55);
    tx_busy = 1;
    pull_tx(b, v);
    chk("R4 tx byte", {24'h0, b}, 32'h55);
    chk("R4 tx valid", {31'h0, v}, 32'h1);
    rd_chk("R10 after drain", 3'd2, 8'hC2);
    rd_chk("R4 busy lsr", 3'd5, 8'h20);
    tx_busy = 0;
    rd_chk("R4 idle lsr", 3'd5, 8'h60);
    wr_reg(3'd1, 8'h00); wr_reg(3'd1, 8'h02);
    chk("R10 enable sets", {31'h0, irq}, 32'h1);
    wr_reg(3'd0, 8'h66);
    chk("R10 write clears", {31'h0, irq}, 32'h0);
    pull_tx(b, v);
    chk("R4 second byte", {24'h0, b}, 32'h66);
    chk("R10 empty again", {31'h0, irq}, 32'h1);

    // R11 modem status
    wr_reg(3'd1, 8'h08);
    modem_in = 4'b0001;
    rd_chk("R11 ms code", 3'd2, 8'hC0);
    rd_chk("R11 msr", 3'd6, 8'h11);
    rd_chk("R11 msr cleared", 3'd6, 8'h10);
    rd_chk("R11 no irq", 3'd2, 8'hC1);
    modem_in = 4'b0101;
    rd_chk("R11 ring rise", 3'd6, 8'h50);
    modem_in = 4'b0001;
    rd_chk("R11 ring fall", 3'd6, 8'h14);

    // R12 outgoing empty over modem
    wr_reg(3'd1, 8'h0F);
    modem_in = 4'b0000;
    rd_chk("R12 thre over ms", 3'd2, 8'hC2);
    rd_chk("R12 ms next", 3'd2, 8'hC0);
    rd_chk("R11 cts fell", 3'd6, 8'h01);

    // random bursts
    wr_reg(3'd1, 8'h00);
    for (int r = 0; r < 30; r++) begin
      int sel, n, n2;
      sel = int'($urandom % 4);
      n   = 1 + int'($urandom % 16);
      wr_reg(3'd2, {2'(sel), 6'b000111});
      wr_reg(3'd1, 8'h01);
      for (int i = 0; i < n; i++) begin
        model[i] = 8'($urandom);
        push_rx(model[i], 3'b000);
      end
      rd_chk("R7 random trigger", 3'd2, b_iir(1'b1, 1'b0, n >= b_trig(sel), 1'b0, 1'b0));
      for (int i = 0; i < n; i++) rd_chk("R3 random rx", 3'd0, model[i]);
      wr_reg(3'd1, 8'h00);
      n2 = 1 + int'($urandom % 16);
      for (int i = 0; i < n2; i++) begin
        model[i] = 8'($urandom);
        wr_reg(3'd0, model[i]);
      end
      for (int i = 0; i < n2; i++) begin
        pull_tx(b, v);
        chk("R4 random tx", {23'h0, v, b}, {23'h0, 1'b1, model[i]});
      end
      @(negedge clk);
      chk("R4 random drained", {31'h0, tx_valid}, 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule